// File: doc/BRIEF.md
# E1 Trunk Timeslot Router

This block sits between the framers of a group of E1 trunks and the internal time-division switching fabric. The framer presents each received byte of a trunk together with its channel index (0 to 31). The router sends the thirty voice channels onto fixed timeslots of that trunk's outgoing stream. It sends channel 16, the common-channel signaling slot, to a dedicated byte port that feeds the trunk's HDLC controller. The frame-alignment channel 0 goes nowhere, because the framer regenerates it.

On the transmit side, the framer requests a channel and receives the line byte one cycle later. A voice channel whose timeslot is connected returns the byte most recently written into that timeslot from the incoming stream. An unconnected voice channel returns the silence code. Channel 16 returns the latest byte from the HDLC controller. Streams and the HDLC port use internal bit order, and the line uses the reverse order, so the internal silence value 0x54 leaves the block as 0x2A.

The signaling path is not configurable. After a reset, or after a pulse on the switch-reset input, the path is held down. While it is down, received signaling bytes are dropped and channel 16 transmits silence. The path returns by itself after a parameterised number of frames.

Top module: `e1_slot_router`

## Requirements
- R1: A received byte on voice channel c (any channel except 0 and 16) of trunk t appears one cycle later on stream t with str_out_vld high, the byte bit-reversed, and timeslot c-1 for c below 16 or c-2 for c above 16.
- R2: A received byte on channel 0 produces no stream output and no HDLC output.
- R3: While the signaling path is up, a received byte on channel 16 appears one cycle later on the trunk's HDLC receive port, bit-reversed, and not on the stream.
- R4: A transmit request for a connected voice channel returns, one cycle later, the bit-reverse of the last byte written into its timeslot through the incoming stream port.
- R5: A transmit request for a voice channel whose conn_mask bit (bit 30*t + timeslot) is clear returns 0x2A in every frame.
- R6: While the signaling path is up, a transmit request for channel 16 returns the bit-reverse of the last byte from the HDLC controller, or 0x7E if the controller has sent nothing since reset.
- R7: A transmit request for channel 0 leaves tx_out_vld low.
- R8: After rst or a sw_reset pulse, sig_down is high from the next cycle on. It falls after RESTORE_FRAMES frame starts (a received channel-0 byte on trunk 0) and stays low until the next reset.
- R9: While sig_down is high, received channel-16 bytes are dropped, and a transmit request for channel 16 returns 0x2A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_reset | input | 1 | Switch-reset pulse; takes the signaling path down |
| rx_vld | input | N_TRUNK | Received byte valid, per trunk |
| rx_ch | input | 5*N_TRUNK | Received channel index, per trunk |
| rx_byte | input | 8*N_TRUNK | Received byte in line bit order |
| str_out_vld | output | N_TRUNK | Outgoing stream byte valid |
| str_out_slot | output | 5*N_TRUNK | Outgoing stream timeslot |
| str_out_byte | output | 8*N_TRUNK | Outgoing stream byte, internal order |
| hdlc_rx_vld | output | N_TRUNK | Signaling byte to HDLC controller valid |
| hdlc_rx_byte | output | 8*N_TRUNK | Signaling byte, internal order |
| str_in_vld | input | N_TRUNK | Incoming stream byte valid |
| str_in_slot | input | 5*N_TRUNK | Incoming stream timeslot (0 to 29) |
| str_in_byte | input | 8*N_TRUNK | Incoming stream byte, internal order |
| conn_mask | input | 30*N_TRUNK | Per-timeslot connected flags |
| hdlc_tx_vld | input | N_TRUNK | Byte from HDLC controller valid |
| hdlc_tx_byte | input | 8*N_TRUNK | Byte from HDLC controller, internal order |
| tx_req | input | N_TRUNK | Framer requests a transmit byte |
| tx_ch | input | 5*N_TRUNK | Requested channel index |
| tx_out_vld | output | N_TRUNK | Transmit byte valid |
| tx_out_byte | output | 8*N_TRUNK | Transmit byte in line bit order |
| sig_down | output | 1 | Signaling path currently disconnected |

## Verification
The bench builds the router with two trunks and RESTORE_FRAMES set to 3. These values keep every channel of both trunks within a full sweep, in both directions. They also let the restore window be counted frame by frame, after both a hard reset and a switch reset. Two trunks show that each trunk keeps its own timeslots and its own signaling path. Mixed connection masks put connected and silent channels side by side in the same frame, over two consecutive frames.

// File: rtl/e1r_pkg.sv
package e1r_pkg;
    localparam int CH_W        = 5;
    localparam int BYTE_W      = 8;
    localparam int VOICE_SLOTS = 30;
    localparam int SIG_CH      = 16;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CH_W-1:0]   chan_t;

    localparam byte_t SILENCE_INT = 8'h54;
    localparam byte_t HDLC_IDLE   = 8'h7E;

    typedef enum logic [1:0] {CK_ALIGN, CK_VOICE, CK_SIGNAL} chan_kind_e;

    typedef struct packed {
        logic  vld;
        chan_t slot;
        byte_t data;
    } slot_beat_t;

    function automatic byte_t flip(byte_t b);
        byte_t r;
        for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
        return r;
    endfunction

    function automatic chan_kind_e kind_of(chan_t c);
        if (c == chan_t'(0))      return CK_ALIGN;
        if (c == chan_t'(SIG_CH)) return CK_SIGNAL;
        return CK_VOICE;
    endfunction

    function automatic chan_t slot_of(chan_t c);
        return (c < chan_t'(SIG_CH)) ? chan_t'(c - chan_t'(1)) : chan_t'(c - chan_t'(2));
    endfunction
endpackage

// File: rtl/e1r_sig_guard.sv
module e1r_sig_guard #(
    parameter int RESTORE_FRAMES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_reset,
    input  logic frame_tick,
    output logic sig_down
);
    localparam int CW = (RESTORE_FRAMES > 1) ? $clog2(RESTORE_FRAMES) : 1;
    localparam logic [CW-1:0] LAST = CW'(RESTORE_FRAMES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || sw_reset) begin
            sig_down <= 1'b1;
            cnt      <= '0;
        end else if (sig_down && frame_tick) begin
            if (cnt == LAST) begin
                sig_down <= 1'b0;
                cnt      <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    p_down_on_swreset_r8: assert property (@(posedge clk) disable iff (rst)
        sw_reset |=> sig_down);
    p_stays_up_r8: assert property (@(posedge clk) disable iff (rst)
        (!sig_down && !sw_reset) |=> !sig_down);
    p_no_rise_without_reset_r8: assert property (@(posedge clk) disable iff (rst)
        !sw_reset |=> !$rose(sig_down));
endmodule

// File: rtl/e1r_rx_split.sv
module e1r_rx_split
    import e1r_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sig_up,
    input  logic       rx_vld,
    input  chan_t      rx_ch,
    input  byte_t      rx_byte,
    output slot_beat_t str_beat,
    output logic       hdlc_vld,
    output byte_t      hdlc_byte
);
    chan_kind_e kind;
    assign kind = kind_of(rx_ch);

    always_ff @(posedge clk) begin
        if (rst) begin
            str_beat  <= '0;
            hdlc_vld  <= 1'b0;
            hdlc_byte <= '0;
        end else begin
            str_beat.vld  <= rx_vld && (kind == CK_VOICE);
            str_beat.slot <= slot_of(rx_ch);
            str_beat.data <= flip(rx_byte);
            hdlc_vld      <= rx_vld && (kind == CK_SIGNAL) && sig_up;
            hdlc_byte     <= flip(rx_byte);
        end
    end

    p_voice_to_stream_r1: assert property (@(posedge clk) disable iff (rst)
        (rx_vld && kind == CK_VOICE) |=> (str_beat.vld && !hdlc_vld
            && str_beat.data == flip($past(rx_byte))));
    p_align_dropped_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_vld && kind == CK_ALIGN) |=> (!str_beat.vld && !hdlc_vld));
    p_sig_to_hdlc_r3: assert property (@(posedge clk) disable iff (rst)
        (rx_vld && kind == CK_SIGNAL && sig_up) |=> (hdlc_vld && !str_beat.vld
            && hdlc_byte == flip($past(rx_byte))));
    p_sig_gated_r9: assert property (@(posedge clk) disable iff (rst)
        !sig_up |=> !hdlc_vld);
endmodule

// File: rtl/e1r_tx_merge.sv
module e1r_tx_merge
    import e1r_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sig_up,
    input  logic                   st_vld,
    input  chan_t                  st_slot,
    input  byte_t                  st_byte,
    input  logic [VOICE_SLOTS-1:0] conn,
    input  logic                   hdlc_vld,
    input  byte_t                  hdlc_byte,
    input  logic                   tx_req,
    input  chan_t                  tx_ch,
    output logic                   tx_vld,
    output byte_t                  tx_byte
);
    byte_t      mem [VOICE_SLOTS];
    byte_t      hreg;
    chan_kind_e kind;
    chan_t      rslot;

    assign kind  = kind_of(tx_ch);
    assign rslot = slot_of(tx_ch);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < VOICE_SLOTS; i++) mem[i] <= SILENCE_INT;
            hreg <= HDLC_IDLE;
        end else begin
            if (st_vld && st_slot < chan_t'(VOICE_SLOTS)) mem[st_slot] <= st_byte;
            if (hdlc_vld) hreg <= hdlc_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_vld  <= 1'b0;
            tx_byte <= '0;
        end else begin
            tx_vld <= tx_req && (kind != CK_ALIGN);
            unique case (kind)
                CK_VOICE:  tx_byte <= conn[rslot] ? flip(mem[rslot]) : flip(SILENCE_INT);
                CK_SIGNAL: tx_byte <= sig_up ? flip(hreg) : flip(SILENCE_INT);
                default:   tx_byte <= flip(SILENCE_INT);
            endcase
        end
    end

    p_align_no_tx_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_req && kind == CK_ALIGN) |=> !tx_vld);
    p_idle_code_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_req && kind == CK_VOICE && !conn[rslot]) |=> (tx_vld && tx_byte == 8'h2A));
    p_sig_silent_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_req && kind == CK_SIGNAL && !sig_up) |=> (tx_vld && tx_byte == 8'h2A));
endmodule

// File: rtl/e1_slot_router.sv
module e1_slot_router
    import e1r_pkg::*;
#(
    parameter int N_TRUNK        = 2,
    parameter int RESTORE_FRAMES = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         sw_reset,
    input  logic [N_TRUNK-1:0]           rx_vld,
    input  logic [N_TRUNK*CH_W-1:0]      rx_ch,
    input  logic [N_TRUNK*BYTE_W-1:0]    rx_byte,
    output logic [N_TRUNK-1:0]           str_out_vld,
    output logic [N_TRUNK*CH_W-1:0]      str_out_slot,
    output logic [N_TRUNK*BYTE_W-1:0]    str_out_byte,
    output logic [N_TRUNK-1:0]           hdlc_rx_vld,
    output logic [N_TRUNK*BYTE_W-1:0]    hdlc_rx_byte,
    input  logic [N_TRUNK-1:0]           str_in_vld,
    input  logic [N_TRUNK*CH_W-1:0]      str_in_slot,
    input  logic [N_TRUNK*BYTE_W-1:0]    str_in_byte,
    input  logic [N_TRUNK*VOICE_SLOTS-1:0] conn_mask,
    input  logic [N_TRUNK-1:0]           hdlc_tx_vld,
    input  logic [N_TRUNK*BYTE_W-1:0]    hdlc_tx_byte,
    input  logic [N_TRUNK-1:0]           tx_req,
    input  logic [N_TRUNK*CH_W-1:0]      tx_ch,
    output logic [N_TRUNK-1:0]           tx_out_vld,
    output logic [N_TRUNK*BYTE_W-1:0]    tx_out_byte,
    output logic                         sig_down
);
    logic frame_tick;
    assign frame_tick = rx_vld[0] && (rx_ch[CH_W-1:0] == '0);

    e1r_sig_guard #(.RESTORE_FRAMES(RESTORE_FRAMES)) u_guard (
        .clk(clk), .rst(rst), .sw_reset(sw_reset),
        .frame_tick(frame_tick), .sig_down(sig_down)
    );

    for (genvar t = 0; t < N_TRUNK; t++) begin : g_trunk
        slot_beat_t beat;

        e1r_rx_split u_rx (
            .clk(clk), .rst(rst), .sig_up(!sig_down),
            .rx_vld(rx_vld[t]),
            .rx_ch(rx_ch[t*CH_W +: CH_W]),
            .rx_byte(rx_byte[t*BYTE_W +: BYTE_W]),
            .str_beat(beat),
            .hdlc_vld(hdlc_rx_vld[t]),
            .hdlc_byte(hdlc_rx_byte[t*BYTE_W +: BYTE_W])
        );

        assign str_out_vld[t]                  = beat.vld;
        assign str_out_slot[t*CH_W +: CH_W]     = beat.slot;
        assign str_out_byte[t*BYTE_W +: BYTE_W] = beat.data;

        e1r_tx_merge u_tx (
            .clk(clk), .rst(rst), .sig_up(!sig_down),
            .st_vld(str_in_vld[t]),
            .st_slot(str_in_slot[t*CH_W +: CH_W]),
            .st_byte(str_in_byte[t*BYTE_W +: BYTE_W]),
            .conn(conn_mask[t*VOICE_SLOTS +: VOICE_SLOTS]),
            .hdlc_vld(hdlc_tx_vld[t]),
            .hdlc_byte(hdlc_tx_byte[t*BYTE_W +: BYTE_W]),
            .tx_req(tx_req[t]),
            .tx_ch(tx_ch[t*CH_W +: CH_W]),
            .tx_vld(tx_out_vld[t]),
            .tx_byte(tx_out_byte[t*BYTE_W +: BYTE_W])
        );
    end
endmodule

// File: tb/sim_e1_slot_router.sv
`timescale 1ns/1ps
module sim_e1_slot_router;
    localparam int NT = 2;
    localparam int RF = 3;

    logic clk = 1'b0;
    logic rst, sw_reset;
    logic [NT-1:0]    rx_vld, str_out_vld, hdlc_rx_vld, str_in_vld, hdlc_tx_vld, tx_req, tx_out_vld;
    logic [NT*5-1:0]  rx_ch, str_out_slot, str_in_slot, tx_ch;
    logic [NT*8-1:0]  rx_byte, str_out_byte, hdlc_rx_byte, str_in_byte, hdlc_tx_byte, tx_out_byte;
    logic [NT*30-1:0] conn_mask;
    logic             sig_down;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    e1_slot_router #(.N_TRUNK(NT), .RESTORE_FRAMES(RF)) u0 (
        .clk(clk), .rst(rst), .sw_reset(sw_reset),
        .rx_vld(rx_vld), .rx_ch(rx_ch), .rx_byte(rx_byte),
        .str_out_vld(str_out_vld), .str_out_slot(str_out_slot), .str_out_byte(str_out_byte),
        .hdlc_rx_vld(hdlc_rx_vld), .hdlc_rx_byte(hdlc_rx_byte),
        .str_in_vld(str_in_vld), .str_in_slot(str_in_slot), .str_in_byte(str_in_byte),
        .conn_mask(conn_mask), .hdlc_tx_vld(hdlc_tx_vld), .hdlc_tx_byte(hdlc_tx_byte),
        .tx_req(tx_req), .tx_ch(tx_ch), .tx_out_vld(tx_out_vld), .tx_out_byte(tx_out_byte),
        .sig_down(sig_down)
    );

    function automatic logic [7:0] rev8(logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic int slot_for(int c);
        return (c < 16) ? c - 1 : c - 2;
    endfunction

    function automatic logic [7:0] rx_pat(int t, int c);
        return 8'((c * 37 + t * 91 + 5) & 255);
    endfunction

    function automatic logic [7:0] st_pat(int t, int s);
        return 8'((s * 53 + t * 29 + 11) & 255);
    endfunction

    function automatic bit is_conn(int t, int s);
        return (t == 0) ? (s % 3 != 0) : (s % 2 == 0);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic idle_all();
        rx_vld = '0; rx_ch = '0; rx_byte = '0;
        str_in_vld = '0; str_in_slot = '0; str_in_byte = '0;
        hdlc_tx_vld = '0; hdlc_tx_byte = '0;
        tx_req = '0; tx_ch = '0; sw_reset = 1'b0;
    endtask

    task automatic rx_one(int t, int c, logic [7:0] b);
        rx_vld[t] = 1'b1; rx_ch[t*5 +: 5] = 5'(c); rx_byte[t*8 +: 8] = b;
        @(negedge clk);
        idle_all();
    endtask

    task automatic tx_one(int t, int c);
        tx_req[t] = 1'b1; tx_ch[t*5 +: 5] = 5'(c);
        @(negedge clk);
        idle_all();
    endtask

    task automatic frame_tick();
        rx_one(0, 0, 8'h1B);
        check("R2 frame tick no stream", 32'(str_out_vld), 0);
        check("R2 frame tick no hdlc", 32'(hdlc_rx_vld), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle_all();
        conn_mask = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        check("R8 sig_down after rst", 32'(sig_down), 1);
        check("R8 outputs idle", 32'({str_out_vld, hdlc_rx_vld, tx_out_vld}), 0);

        // R9: while down, signaling dropped and silent
        rx_one(0, 16, 8'hC3);
        check("R9 hdlc dropped while down", 32'(hdlc_rx_vld), 0);
        check("R9 no stream for ch16", 32'(str_out_vld), 0);
        tx_one(1, 16);
        check("R9 tx ch16 silent vld", 32'(tx_out_vld[1]), 1);
        check("R9 tx ch16 silent byte", 32'(tx_out_byte[15:8]), 32'h2A);

        // R8: restore after RF frames
        for (int f = 0; f < RF; f++) begin
            check("R8 still down before restore", 32'(sig_down), 1);
            frame_tick();
        end
        check("R8 up after restore", 32'(sig_down), 0);

        // R1 R2 R3: receive sweep
        for (int t = 0; t < NT; t++) begin
            for (int c = 0; c < 32; c++) begin
                rx_one(t, c, rx_pat(t, c));
                if (c == 0) begin
                    check("R2 ch0 no output", 32'({str_out_vld, hdlc_rx_vld}), 0);
                end else if (c == 16) begin
                    check("R3 hdlc vld", 32'(hdlc_rx_vld), 32'(1 << t));
                    check("R3 hdlc byte", 32'(hdlc_rx_byte[t*8 +: 8]), 32'(rev8(rx_pat(t, c))));
                    check("R3 no stream", 32'(str_out_vld), 0);
                end else begin
                    check("R1 stream vld", 32'(str_out_vld), 32'(1 << t));
                    check("R1 stream slot", 32'(str_out_slot[t*5 +: 5]), 32'(slot_for(c)));
                    check("R1 stream byte", 32'(str_out_byte[t*8 +: 8]), 32'(rev8(rx_pat(t, c))));
                end
            end
        end

        // R6: idle HDLC byte before any write
        tx_one(0, 16);
        check("R6 ch16 before write", 32'(tx_out_byte[7:0]), 32'h7E);

        // fill incoming streams
        for (int t = 0; t < NT; t++) begin
            for (int s = 0; s < 30; s++) begin
                str_in_vld[t] = 1'b1; str_in_slot[t*5 +: 5] = 5'(s); str_in_byte[t*8 +: 8] = st_pat(t, s);
                @(negedge clk);
                idle_all();
                conn_mask[t*30 + s] = is_conn(t, s);
            end
        end
        hdlc_tx_vld[1] = 1'b1; hdlc_tx_byte[15:8] = 8'h1C;
        @(negedge clk);
        idle_all();

        // R4 R5 R6 R7: transmit sweep over two frames
        for (int f = 0; f < 2; f++) begin
            for (int t = 0; t < NT; t++) begin
                for (int c = 0; c < 32; c++) begin
                    tx_one(t, c);
                    if (c == 0) begin
                        check("R7 ch0 no tx", 32'(tx_out_vld), 0);
                    end else if (c == 16) begin
                        check("R6 ch16 vld", 32'(tx_out_vld[t]), 1);
                        check("R6 ch16 byte", 32'(tx_out_byte[t*8 +: 8]),
                              32'((t == 1) ? rev8(8'h1C) : 8'h7E));
                    end else if (is_conn(t, slot_for(c))) begin
                        check("R4 connected vld", 32'(tx_out_vld[t]), 1);
                        check("R4 connected byte", 32'(tx_out_byte[t*8 +: 8]),
                              32'(rev8(st_pat(t, slot_for(c)))));
                    end else begin
                        check("R5 silence vld", 32'(tx_out_vld[t]), 1);
                        check("R5 silence byte", 32'(tx_out_byte[t*8 +: 8]), 32'h2A);
                    end
                end
            end
        end

        // R8 R9: switch reset drops the signaling path
        sw_reset = 1'b1;
        @(negedge clk);
        idle_all();
        check("R8 down after sw_reset", 32'(sig_down), 1);
        rx_one(1, 16, 8'h66);
        check("R9 hdlc dropped after sw_reset", 32'(hdlc_rx_vld), 0);
        tx_one(1, 16);
        check("R9 tx ch16 silent after sw_reset", 32'(tx_out_byte[15:8]), 32'h2A);
        rx_one(1, 0, 8'h00);
        check("R8 trunk1 ch0 is no frame tick", 32'(sig_down), 1);
        for (int f = 0; f < RF; f++) begin
            check("R8 down during window", 32'(sig_down), 1);
            frame_tick();
        end
        check("R8 up after sw_reset window", 32'(sig_down), 0);
        tx_one(1, 16);
        check("R6 ch16 restored byte", 32'(tx_out_byte[15:8]), 32'(rev8(8'h1C)));
        rx_one(0, 16, 8'h81);
        check("R3 hdlc restored", 32'(hdlc_rx_byte[7:0]), 32'(rev8(8'h81)));

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule